// File: doc/BRIEF.md
# Word-Parallel Modular Adder/Subtractor

This block adds or subtracts two operands modulo a prime that is loaded beforehand. Each operand is `N` words of `W` bits, so `n = N*W` bits in all. Both operands must already be below the modulus. The caller presents the operands and the operation together with a one-cycle `start` pulse. The reduced result appears on a register one clock later, marked by a one-cycle `res_valid` pulse.

Inside the block, every word has its own processing element. Each element forms two candidate words in parallel. The first is the plain sum or difference. The second has the correction constant already added: the modulus when subtracting, and its two's complement when adding. The second path merges three operands in carry-save form, so each word still has at most one carry out. Two prefix carry networks, one per path, resolve the carries between words in logarithmic depth. One decision bit, taken from the top carries, then picks the path for every word at once.

The modulus is written through a load port. Its two's complement is formed and stored at the same time, so that the correction constant is ready word by word.

Top module: `wmod_addsub`

## Requirements
- R1: With `op_sub`=0 and A+B < P, the result is A+B.
- R2: With `op_sub`=0 and A+B >= P, the result is A+B-P. This includes sums that carry out of bit n-1.
- R3: With `op_sub`=1 and A >= B, the result is A-B. Equal operands give 0.
- R4: With `op_sub`=1 and A < B, the result is A-B+P.
- R5: `res_valid` is high for exactly the one cycle after a cycle with `start` high, and low after every cycle without `start`.
- R6: `res` keeps its value in every cycle that follows a cycle without `start`.
- R7: While reset is asserted, `res_valid` and `res` are 0, and the stored modulus is 0.
- R8: A modulus written with `mod_wr` governs only operations started in later cycles. An operation started in the same cycle as the write still uses the previous modulus.
- R9: Results are exact when a carry or borrow has to pass through every word boundary. Examples are a low part of all ones plus one, and a power of two minus one.
- R10: For operands below the loaded nonzero modulus, every result is below that modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_wr | input | 1 | Load `mod_val` as the new modulus |
| mod_val | input | N*W | Modulus value to load |
| start | input | 1 | Launch one operation with the current operands |
| op_sub | input | 1 | 0 = modular add, 1 = modular subtract |
| opa | input | N*W | Operand A, word 0 in the low bits |
| opb | input | N*W | Operand B, word 0 in the low bits |
| res_valid | output | 1 | One-cycle pulse: `res` holds a new result |
| res | output | N*W | Registered reduced result |

## Verification
The range assertion assumes that a nonzero modulus has been loaded. It fires only when both operands, sampled at `start`, are below the modulus in force at that moment. Operands outside that range carry no promise, so the checker tracks the modulus itself and leaves those cases out. The bench reduces every operand modulo the current prime before issuing it, and it includes values exactly at P-1 and at 0. A prime close to 2^n lets additions overflow the n-bit width, which exercises the overflow branch of the add rule.

// File: rtl/wmod_pkg.sv
package wmod_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } wmod_op_e;

endpackage

// File: rtl/wmod_pe.sv
module wmod_pe #(
  parameter int W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  input  logic         inv_b,
  input  logic         csa_in,
  output logic [W:0]   f_raw,
  output logic [W:0]   s_raw,
  output logic         csa_out
);
  logic [W-1:0] bx;
  logic [W-1:0] xs;
  logic [W-1:0] yc;

  // B is inverted for subtraction; the +1 of the negation enters at word 0
  assign bx = inv_b ? ~b : b;

  // carry-save merge of a, b', k so the corrected path keeps one carry per word
  assign xs = a ^ bx ^ k;
  assign yc = (a & bx) | (a & k) | (bx & k);

  assign f_raw   = {1'b0, a} + {1'b0, bx};
  assign s_raw   = {1'b0, xs} + {1'b0, yc[W-2:0], csa_in};
  assign csa_out = yc[W-1];
endmodule

// File: rtl/wmod_cproj.sv
module wmod_cproj #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry
);
  localparam int M  = N + 1;
  localparam int LV = (M > 1) ? $clog2(M) : 1;

  logic [N:0] g_cur, p_cur, g_nxt, p_nxt;

  // Kogge-Stone prefix over (cin, word 0 .. word N-1); carry[i] enters word i
  always_comb begin
    g_cur = {gen, cin};
    p_cur = {prop, 1'b0};
    g_nxt = g_cur;
    p_nxt = p_cur;
    for (int l = 0; l < LV; l++) begin
      g_nxt = g_cur;
      p_nxt = p_cur;
      for (int j = 0; j < M; j++) begin
        if (j >= (1 << l)) begin
          g_nxt[j] = g_cur[j] | (p_cur[j] & g_cur[j-(1<<l)]);
          p_nxt[j] = p_cur[j] & p_cur[j-(1<<l)];
        end
      end
      g_cur = g_nxt;
      p_cur = p_nxt;
    end
    carry = g_cur;
  end
endmodule

// File: rtl/wmod_addsub.sv
module wmod_addsub
  import wmod_pkg::*;
#(
  parameter int W = 17,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mod_wr,
  input  logic [N*W-1:0] mod_val,
  input  logic           start,
  input  logic           op_sub,
  input  logic [N*W-1:0] opa,
  input  logic [N*W-1:0] opb,
  output logic           res_valid,
  output logic [N*W-1:0] res
);
  localparam int NW = N * W;

  wmod_op_e op;
  assign op = wmod_op_e'(op_sub);

  // ---------------- modulus and its two's complement ----------------
  logic [NW-1:0] p_q, p_d, ip_q, ip_d;

  always_comb begin
    p_d  = p_q;
    ip_d = ip_q;
    if (mod_wr) begin
      p_d  = mod_val;
      ip_d = '0 - mod_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= '0;
      ip_q <= '0;
    end else if (mod_wr) begin
      p_q  <= p_d;
      ip_q <= ip_d;
    end
  end

  // ---------------- per-word processing elements ----------------
  logic [N-1:0][W:0] f_raw, s_raw;
  logic [N:0]        csa_c;
  logic [N-1:0]      f_g, f_p, s_g, s_p;
  logic [N:0]        f_c, s_c;
  logic [NW-1:0]     r_f, r_s;

  assign csa_c[0] = (op == OP_SUB);

  generate
    for (genvar i = 0; i < N; i++) begin : g_word
      logic [W-1:0] k_w;
      assign k_w = (op == OP_SUB) ? p_q[i*W +: W] : ip_q[i*W +: W];

      wmod_pe #(.W(W)) u_pe (
        .a       (opa[i*W +: W]),
        .b       (opb[i*W +: W]),
        .k       (k_w),
        .inv_b   (op == OP_SUB),
        .csa_in  (csa_c[i]),
        .f_raw   (f_raw[i]),
        .s_raw   (s_raw[i]),
        .csa_out (csa_c[i+1])
      );

      assign f_g[i] = f_raw[i][W];
      assign f_p[i] = &f_raw[i][W-1:0];
      assign s_g[i] = s_raw[i][W];
      assign s_p[i] = &s_raw[i][W-1:0];

      assign r_f[i*W +: W] = f_raw[i][W-1:0] + W'(f_c[i]);
      assign r_s[i*W +: W] = s_raw[i][W-1:0] + W'(s_c[i]);
    end
  endgenerate

  // ---------------- carry projection, one per path ----------------
  wmod_cproj #(.N(N)) u_cp_first (
    .gen   (f_g),
    .prop  (f_p),
    .cin   (op == OP_SUB),
    .carry (f_c)
  );

  wmod_cproj #(.N(N)) u_cp_second (
    .gen   (s_g),
    .prop  (s_p),
    .cin   (1'b0),
    .carry (s_c)
  );

  // add: corrected path when A+B+(2^n-P) reaches 2^n, i.e. A+B >= P
  // sub: corrected path when A+~B+1 has no carry out, i.e. A < B
  logic use_second;
  always_comb begin
    if (op == OP_SUB) use_second = ~f_c[N];
    else              use_second = csa_c[N] | s_c[N];
  end

  // ---------------- output register ----------------
  logic [NW-1:0] res_q, res_d;
  logic          vld_q, vld_d;

  always_comb begin
    vld_d = start;
    res_d = res_q;
    if (start) res_d = use_second ? r_s : r_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (start) res_q <= res_d;
    end
  end

  assign res       = res_q;
  assign res_valid = vld_q;
endmodule

// File: rtl/wmod_addsub_chk.sv
module wmod_addsub_chk #(
  parameter int W = 17,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mod_wr,
  input logic [N*W-1:0] mod_val,
  input logic           start,
  input logic           op_sub,
  input logic [N*W-1:0] opa,
  input logic [N*W-1:0] opb,
  input logic           res_valid,
  input logic [N*W-1:0] res
);
  logic [N*W-1:0] p_sh, p_used;
  logic           in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sh   <= '0;
      p_used <= '0;
      in_q   <= 1'b0;
    end else begin
      if (mod_wr) p_sh <= mod_val;
      if (start) begin
        p_used <= p_sh;
        in_q   <= (p_sh != '0) && (opa < p_sh) && (opb < p_sh);
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid); // R5
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid); // R5
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(res)); // R6
  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sub && (opa == opb)) |=> (res == '0)); // R3
  AST_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && in_q) |-> (res < p_used)); // R10
endmodule

bind wmod_addsub wmod_addsub_chk #(.W(W), .N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_wr    (mod_wr),
  .mod_val   (mod_val),
  .start     (start),
  .op_sub    (op_sub),
  .opa       (opa),
  .opb       (opb),
  .res_valid (res_valid),
  .res       (res)
);

// File: tb/tb_wmod_addsub.sv
`timescale 1ns/1ps
module tb_wmod_addsub;
  localparam int W  = 17;
  localparam int N  = 4;
  localparam int NW = N * W;

  logic          clk, rst_n, mod_wr, start, op_sub, res_valid;
  logic [NW-1:0] mod_val, opa, opb, res;

  wmod_addsub #(.W(W), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .mod_wr(mod_wr), .mod_val(mod_val),
    .start(start), .op_sub(op_sub), .opa(opa), .opb(opb),
    .res_valid(res_valid), .res(res)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R7 reset";

  // ---------------- behavioural reference ----------------
  logic [NW-1:0] p_ref, exp_res;
  logic          exp_vld;

  function automatic logic [NW-1:0] model(input logic [NW-1:0] a, b, p, input logic sub);
    logic [NW:0] s;
    if (!sub) begin
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, p}) s = s - {1'b0, p};
    end else begin
      if (a >= b) s = {1'b0, a} - {1'b0, b};
      else        s = {1'b0, a} - {1'b0, b} + {1'b0, p};
    end
    return s[NW-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ref   <= '0;
      exp_res <= '0;
      exp_vld <= 1'b0;
    end else begin
      exp_vld <= start;
      if (start) exp_res <= model(opa, opb, p_ref, op_sub);
      if (mod_wr) p_ref <= mod_val;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (res_valid !== exp_vld || res !== exp_res) begin
        n_bad++;
        $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
                 cur_tag, res_valid, res, exp_vld, exp_res);
      end
    end
  end

  task automatic run_op(input logic [NW-1:0] a, b, input logic sub, input string tag);
    @(negedge clk);
    cur_tag = tag;
    opa = a; opb = b; op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load_mod(input logic [NW-1:0] p);
    @(negedge clk);
    mod_val = p; mod_wr = 1'b1;
    @(negedge clk);
    mod_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  localparam logic [NW-1:0] P1 = 68'hF_FFFF_FFFF_FFFF_FFC5;
  localparam logic [NW-1:0] P2 = 68'h8_0000_0000_0001_FFFF;
  localparam logic [NW-1:0] LOWS = (68'h1 << 51) - 1; // low three words all ones

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mod_wr = 1'b0; start = 1'b0; op_sub = 1'b0;
    mod_val = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++; // R7: outputs cleared during reset
    if (res_valid !== 1'b0 || res !== '0) begin
      n_bad++;
      $display("FAIL R7: valid=%0b res=%h expected valid=0 res=0", res_valid, res);
    end
    rst_n = 1'b1;

    // R7: modulus starts at 0, so 0-1 wraps to all ones
    run_op('0, 68'h1, 1'b1, "R7 modulus zero after reset");

    load_mod(P1);
    run_op(68'h5, 68'h7, 1'b0, "R1 small add");
    run_op(P1 - 68'h10, 68'hF, 1'b0, "R1 sum P-1");
    run_op(P1 - 68'h10, 68'h10, 1'b0, "R2 sum equals P");
    run_op(P1 - 1, P1 - 1, 1'b0, "R2 overflow past 2^n");
    run_op(68'h123456789, 68'h123456789, 1'b1, "R3 equal operands");
    run_op(P1 - 1, 68'h1, 1'b1, "R3 a>=b");
    run_op('0, 68'h1, 1'b1, "R4 0-1");
    run_op(68'h3, P1 - 1, 1'b1, "R4 a<b");
    run_op(LOWS, 68'h1, 1'b0, "R9 carry through all words");
    run_op(68'h1 << 51, 68'h1, 1'b1, "R9 borrow through all words");
    run_op(P1 - 1, LOWS, 1'b0, "R9 wide add");
    repeat (3) @(negedge clk); // R5/R6: idle cycles, no valid, result held

    // R8: write and start in the same cycle -> old modulus
    @(negedge clk);
    cur_tag = "R8 same-cycle load uses old modulus";
    mod_val = P2; mod_wr = 1'b1;
    opa = '0; opb = 68'h2; op_sub = 1'b1; start = 1'b1;
    @(negedge clk);
    mod_wr = 1'b0; start = 1'b0;
    run_op('0, 68'h2, 1'b1, "R8 new modulus in force");
    run_op(P2 - 1, 68'h5, 1'b0, "R8 R2 wrap with new modulus");

    // back-to-back starts (R5)
    @(negedge clk);
    cur_tag = "R5 back-to-back";
    opa = 68'h9; opb = 68'h4; op_sub = 1'b1; start = 1'b1;
    @(negedge clk);
    opa = P2 - 2; opb = 68'h7; op_sub = 1'b0;
    @(negedge clk);
    start = 1'b0;

    // mixed patterns for R1 R2 R3 R4 R10
    for (int i = 0; i < 60; i++) begin
      logic [95:0]   t1, t2;
      logic [NW-1:0] pm;
      pm = (i < 30) ? P2 : P1;
      if (i == 30) load_mod(P1);
      t1 = {$urandom, $urandom, $urandom};
      t2 = {$urandom, $urandom, $urandom};
      run_op(NW'(t1 % 96'(pm)), NW'(t2 % 96'(pm)), i[0], "R1 R2 R3 R4 R10 mixed");
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule